// File: doc/BRIEF.md
# I2C SCL and Bus Timing Generator

This block produces the serial clock of an I2C master and marks the instants at which a byte-level sequencer must move SDA. A sequencer issues one bus command at a time: start, one bit slot, repeated start or stop. The block then steps through the timed phases of that command. It pulls SCL low through an open-drain enable and pulses a strobe at each SDA event. A final `done` pulse closes the command. Between commands the bus is either free (SCL released) or held (SCL pulled low after a start or a bit).

All phase lengths come from packed 32-bit timing words. A prescaler divides the input clock by DIV+1, and every phase lasts its programmed count plus one prescaled tick. When SCL is released, the block waits a fixed eight input clocks plus the glitch-filter cycle count before it starts the high count. The high count also waits until the synchronised SCL line reads high, so a slave that stretches the clock lengthens the bit. There are two timing banks. In high-speed mode the block runs on the fast bank until the master-code bits have completed, then uses the high-speed bank until the next stop.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: With SCL free to rise, a bit slot lasts exactly (DIV+1)*(SCL_L+SCL_H+2)+8+FLT input clocks, counted from the accepting clock edge through the cycle in which `done` is high. SCL_L is word 2 bits [15:8], SCL_H is word 2 bits [7:0] and DIV is word 3 bits [23:16]. All other bits of words 1 to 3 and bits [31:8] of the hold word have no effect.
- R2: FLT is taken from `cfg_word` bits [18:16] and adds FLT input clocks to every released-SCL phase. The FLT_DOUBLE parameter makes it add 2*FLT instead.
- R3: A start from the free bus keeps SCL released and pulses `evt_sda_fall` in clock (SU+1)*(DIV+1). It then pulses `done` in clock (SU+1)*(DIV+1)+(HD+1)*(DIV+1), after which SCL is held low. SU is word 1 bits [31:24] and HD is word 1 bits [23:16].
- R4: In every low phase, `evt_data` pulses once, in clock (DH+1)*(DIV+1) of that phase, where DH is hold-word bits [7:0] and is shared by both banks. `evt_data` is only ever high while SCL is pulled low.
- R5: A stop lasts (DIV+1)*(SCL_L+1)+8+FLT+(PS+1)*(DIV+1) clocks, where PS is word 1 bits [15:8]. `evt_sda_rise` and `done` pulse together in its last clock with SCL released, and the bus is then free.
- R6: A repeated start lasts a low phase, the release overhead, (SR+1)*(DIV+1) clocks of high time and then a full start sequence, where SR is word 3 bits [7:0]. It ends with SCL held low.
- R7: The high count starts only once the synchronised SCL reads high. If the line is held low until clock X of the release phase, `done` comes 2+(SCL_H+1)*(DIV+1) clocks after that.
- R8: With `hs_enable` high, the fast bank is used from the start through the ninth completed bit. The high-speed bank is used from the tenth bit until a stop completes. `hs_bank_active` shows the bank in use and is low while `hs_enable` is low.
- R9: Only a start is accepted on a free bus, and only bit, stop or repeated start on a held bus. `cmd_op` codes are 0 start, 1 bit, 2 repeated start, 3 stop. Any other command leaves SCL and `cmd_ready` unchanged and produces no `done`.
- R10: The timing fields, bank choice and filter count are captured when a command is accepted. Changes to them during a command do not alter that command.
- R11: After reset, SCL is released, `cmd_ready` is high, every strobe is low and the fast bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word, filter count in [18:16] |
| fs_w1 | input | 32 | Fast bank word 1: start setup, start hold, stop setup |
| fs_w2 | input | 32 | Fast bank word 2: SCL low and high counts |
| fs_w3 | input | 32 | Fast bank word 3: prescale divider, repeated-start release |
| hs_w1 | input | 32 | High-speed bank word 1 |
| hs_w2 | input | 32 | High-speed bank word 2 |
| hs_w3 | input | 32 | High-speed bank word 3 |
| hold_w | input | 32 | Data hold count in [7:0], shared by both banks |
| hs_enable | input | 1 | High-speed operation requested |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code |
| scl_in | input | 1 | Sampled SCL line |
| scl_pull_low | output | 1 | Open-drain SCL drive, 1 pulls the line low |
| cmd_ready | output | 1 | Bus free or held, waiting for a command |
| evt_sda_fall | output | 1 | Sequencer pulls SDA low now (start) |
| evt_sda_rise | output | 1 | Sequencer releases SDA now (stop) |
| evt_data | output | 1 | Data hold elapsed, SDA may change |
| evt_sample | output | 1 | SCL seen high, SDA may be sampled |
| done | output | 1 | Last clock of the current command |
| hs_bank_active | output | 1 | High-speed bank selected |

## Verification
On every cycle the checker watches the bus-level rules. Start and stop edges happen only with SCL released. Data changes happen only with SCL low. The strobes never collide. `done` is always followed by a ready state, and the bank switches only at the end of a command. The exact clock counts of each phase have to come from the bench scenarios: the period formula for several divider and filter settings, the minimum and maximum divider, the stretched release and the ninth-bit bank switch. The same holds for commands ignored in the wrong bus state and for words changed in the middle of a command.

// File: rtl/i2c_tgen_pkg.sv
`timescale 1ns/1ps
package i2c_tgen_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_BIT     = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ST_SU,
        S_ST_HD,
        S_PARK,
        S_BIT_LO,
        S_BIT_REL,
        S_BIT_HI,
        S_SP_LO,
        S_SP_REL,
        S_SP_SU,
        S_RS_LO,
        S_RS_REL,
        S_RS_HI
    } state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] div;
        logic [FIELD_W-1:0] scl_lo;
        logic [FIELD_W-1:0] scl_hi;
        logic [FIELD_W-1:0] st_su;
        logic [FIELD_W-1:0] st_hd;
        logic [FIELD_W-1:0] sp_su;
        logic [FIELD_W-1:0] sr_rel;
        logic [FIELD_W-1:0] dat_hd;
    } timing_t;

endpackage

// File: rtl/i2c_tgen_timer.sv
`timescale 1ns/1ps
// Prescaled phase timer: one tick every div+1 clocks; the phase ends on
// the tick where the tick count equals limit.
module i2c_tgen_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] div,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] mark,
    output logic         fin,
    output logic         mark_hit
);
    logic [W-1:0] pre_q;
    logic [W-1:0] cnt_q;
    logic         tick;

    assign tick     = (pre_q == div);
    assign fin      = tick && (cnt_q == limit);
    assign mark_hit = tick && (cnt_q == mark);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgen_sync.sv
`timescale 1ns/1ps
// SCL input synchroniser plus the release overhead counter (fixed part
// plus filter cycles), counted in raw input clocks.
module i2c_tgen_sync #(
    parameter int STAGES = 2,
    parameter int OVH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             clr,
    input  logic [OVH_W-1:0] ovh_len,
    output logic             scl_high,
    output logic             ovh_done
);
    logic [STAGES-1:0] sync_q;
    logic [OVH_W-1:0]  ovh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], scl_in};
    end

    assign scl_high = sync_q[STAGES-1];
    assign ovh_done = (ovh_q >= (ovh_len - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovh_q <= '0;
        else if (clr)       ovh_q <= '0;
        else if (!ovh_done) ovh_q <= ovh_q + 1'b1;
    end
endmodule

// File: rtl/i2c_tgen_bank.sv
`timescale 1ns/1ps
// Decodes both timing banks and tracks the master-code bit count that
// moves high-speed operation from the fast bank to the high-speed bank.
module i2c_tgen_bank
    import i2c_tgen_pkg::*;
#(
    parameter int MC_BITS = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hs_enable,
    input  logic [31:0] fs_w1,
    input  logic [31:0] fs_w2,
    input  logic [31:0] fs_w3,
    input  logic [31:0] hs_w1,
    input  logic [31:0] hs_w2,
    input  logic [31:0] hs_w3,
    input  logic [31:0] hold_w,
    input  logic        start_done,
    input  logic        bit_done,
    input  logic        stop_done,
    output timing_t     sel,
    output logic        hs_active
);
    localparam int MC_W = $clog2(MC_BITS + 1);

    logic [31:0] w1_a [2];
    logic [31:0] w2_a [2];
    logic [31:0] w3_a [2];
    timing_t     dec  [2];
    logic [MC_W-1:0] mc_q;

    assign w1_a[0] = fs_w1;
    assign w1_a[1] = hs_w1;
    assign w2_a[0] = fs_w2;
    assign w2_a[1] = hs_w2;
    assign w3_a[0] = fs_w3;
    assign w3_a[1] = hs_w3;

    for (genvar b = 0; b < 2; b++) begin : g_dec
        assign dec[b].st_su  = w1_a[b][31:24];
        assign dec[b].st_hd  = w1_a[b][23:16];
        assign dec[b].sp_su  = w1_a[b][15:8];
        assign dec[b].scl_lo = w2_a[b][15:8];
        assign dec[b].scl_hi = w2_a[b][7:0];
        assign dec[b].div    = w3_a[b][23:16];
        assign dec[b].sr_rel = w3_a[b][7:0];
        assign dec[b].dat_hd = hold_w[7:0];
    end

    logic unused_fields;
    assign unused_fields = ^{fs_w1[7:0], fs_w2[31:16], fs_w3[31:24], fs_w3[15:8],
                             hs_w1[7:0], hs_w2[31:16], hs_w3[31:24], hs_w3[15:8],
                             hold_w[31:8]};

    assign sel = hs_active ? dec[1] : dec[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_active <= 1'b0;
            mc_q      <= '0;
        end else if (!hs_enable || start_done || stop_done) begin
            hs_active <= 1'b0;
            mc_q      <= '0;
        end else if (bit_done && !hs_active) begin
            if (mc_q == MC_W'(MC_BITS - 1)) begin
                hs_active <= 1'b1;
                mc_q      <= '0;
            end else begin
                mc_q <= mc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module i2c_scl_timing_gen
    import i2c_tgen_pkg::*;
#(
    parameter int FLT_W       = 3,
    parameter int FLT_DOUBLE  = 0,
    parameter int MC_BITS     = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_word,
    input  logic [31:0] fs_w1,
    input  logic [31:0] fs_w2,
    input  logic [31:0] fs_w3,
    input  logic [31:0] hs_w1,
    input  logic [31:0] hs_w2,
    input  logic [31:0] hs_w3,
    input  logic [31:0] hold_w,
    input  logic        hs_enable,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        scl_in,
    output logic        scl_pull_low,
    output logic        cmd_ready,
    output logic        evt_sda_fall,
    output logic        evt_sda_rise,
    output logic        evt_data,
    output logic        evt_sample,
    output logic        done,
    output logic        hs_bank_active
);
    localparam int FIXED_OVH = 8;
    localparam int OVH_W     = $clog2(FIXED_OVH + ((2**FLT_W) - 1) * 2 + 1);

    state_e  state_q, state_d;
    op_e     op_in, cur_op_q;
    timing_t sel_t, tim_q;
    logic [OVH_W-1:0]   ovh_len_q, ovh_len_d;
    logic [FLT_W-1:0]   flt;
    logic [FIELD_W-1:0] lim, mark;
    logic fin, mark_hit, scl_high, ovh_done, clr, accept;

    logic unused_cfg;
    assign unused_cfg = ^{cfg_word[31:19], cfg_word[15:0]};

    assign op_in     = op_e'(cmd_op);
    assign flt       = cfg_word[16 +: FLT_W];
    assign ovh_len_d = OVH_W'(FIXED_OVH) + (OVH_W'(flt) << FLT_DOUBLE);
    assign clr       = (state_d != state_q);
    assign accept    = cmd_valid &&
                       (((state_q == S_IDLE) && (op_in == OP_START)) ||
                        ((state_q == S_PARK) && (op_in != OP_START)));

    i2c_tgen_bank #(.MC_BITS(MC_BITS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_enable  (hs_enable),
        .fs_w1      (fs_w1),
        .fs_w2      (fs_w2),
        .fs_w3      (fs_w3),
        .hs_w1      (hs_w1),
        .hs_w2      (hs_w2),
        .hs_w3      (hs_w3),
        .hold_w     (hold_w),
        .start_done (done && (cur_op_q == OP_START)),
        .bit_done   (done && (cur_op_q == OP_BIT)),
        .stop_done  (done && (cur_op_q == OP_STOP)),
        .sel        (sel_t),
        .hs_active  (hs_bank_active)
    );

    i2c_tgen_timer #(.W(FIELD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .div      (tim_q.div),
        .limit    (lim),
        .mark     (mark),
        .fin      (fin),
        .mark_hit (mark_hit)
    );

    i2c_tgen_sync #(.STAGES(SYNC_STAGES), .OVH_W(OVH_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .clr      (clr),
        .ovh_len  (ovh_len_q),
        .scl_high (scl_high),
        .ovh_done (ovh_done)
    );

    // Capture of the command's timing set at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q     <= '0;
            ovh_len_q <= OVH_W'(FIXED_OVH);
            cur_op_q  <= OP_START;
        end else if (accept) begin
            tim_q     <= sel_t;
            ovh_len_q <= ovh_len_d;
            cur_op_q  <= op_in;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and phase limit selection.
    always_comb begin
        state_d = state_q;
        lim     = tim_q.scl_lo;
        mark    = tim_q.dat_hd;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_ST_SU;
            S_ST_SU:   begin lim = tim_q.st_su;  if (fin) state_d = S_ST_HD; end
            S_ST_HD:   begin lim = tim_q.st_hd;  if (fin) state_d = S_PARK;  end
            S_PARK: begin
                if (accept) begin
                    unique case (op_in)
                        OP_BIT:     state_d = S_BIT_LO;
                        OP_STOP:    state_d = S_SP_LO;
                        OP_RESTART: state_d = S_RS_LO;
                        default:    state_d = S_PARK;
                    endcase
                end
            end
            S_BIT_LO:  if (fin) state_d = S_BIT_REL;
            S_BIT_REL: if (ovh_done && scl_high) state_d = S_BIT_HI;
            S_BIT_HI:  begin lim = tim_q.scl_hi; if (fin) state_d = S_PARK;  end
            S_SP_LO:   if (fin) state_d = S_SP_REL;
            S_SP_REL:  if (ovh_done && scl_high) state_d = S_SP_SU;
            S_SP_SU:   begin lim = tim_q.sp_su;  if (fin) state_d = S_IDLE;  end
            S_RS_LO:   if (fin) state_d = S_RS_REL;
            S_RS_REL:  if (ovh_done && scl_high) state_d = S_RS_HI;
            S_RS_HI:   begin lim = tim_q.sr_rel; if (fin) state_d = S_ST_SU; end
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        scl_pull_low = 1'b0;
        cmd_ready    = 1'b0;
        evt_sda_fall = 1'b0;
        evt_sda_rise = 1'b0;
        evt_data     = 1'b0;
        evt_sample   = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            S_IDLE:    cmd_ready = 1'b1;
            S_PARK:    begin cmd_ready = 1'b1; scl_pull_low = 1'b1; end
            S_ST_SU:   evt_sda_fall = fin;
            S_ST_HD:   done = fin;
            S_BIT_LO, S_SP_LO, S_RS_LO: begin
                scl_pull_low = 1'b1;
                evt_data     = mark_hit;
            end
            S_BIT_REL: evt_sample = ovh_done && scl_high;
            S_BIT_HI:  done = fin;
            S_SP_SU:   begin evt_sda_rise = fin; done = fin; end
            S_SP_REL, S_RS_REL, S_RS_HI: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/i2c_tgen_chk.sv
`timescale 1ns/1ps
module i2c_tgen_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_pull_low,
    input logic cmd_ready,
    input logic evt_sda_fall,
    input logic evt_sda_rise,
    input logic evt_data,
    input logic evt_sample,
    input logic done,
    input logic hs_enable,
    input logic hs_bank_active
);
    assert_start_scl_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sda_fall |-> !scl_pull_low);

    assert_data_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_data |-> scl_pull_low);

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_sda_fall, evt_data, evt_sample}));

    assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sda_rise |-> (done && !scl_pull_low));

    assert_sample_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sample |-> !scl_pull_low);

    assert_bank_switch_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_bank_active) |-> $past(done));

    assert_bank_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_enable |=> !hs_bank_active);

    assert_done_then_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

    assert_no_done_while_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !done);
endmodule

bind i2c_scl_timing_gen i2c_tgen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_pull_low   (scl_pull_low),
    .cmd_ready      (cmd_ready),
    .evt_sda_fall   (evt_sda_fall),
    .evt_sda_rise   (evt_sda_rise),
    .evt_data       (evt_data),
    .evt_sample     (evt_sample),
    .done           (done),
    .hs_enable      (hs_enable),
    .hs_bank_active (hs_bank_active)
);

// File: tb/test_i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [31:0] fs_w1 = '0, fs_w2 = '0, fs_w3 = '0;
    logic [31:0] hs_w1 = '0, hs_w2 = '0, hs_w3 = '0;
    logic [31:0] hold_w = '0;
    logic        hs_enable = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        stretch_hold = 1'b0;
    logic        scl_in;
    logic        scl_pull_low, cmd_ready, evt_sda_fall, evt_sda_rise;
    logic        evt_data, evt_sample, done, hs_bank_active;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        int    t_done;
        int    t_evt;
        string req;
    } exp_t;
    exp_t sb[$];

    bit evt_seen = 1'b0;
    int evt_cyc = 0;

    assign scl_in = !(scl_pull_low || stretch_hold);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_scl_timing_gen i_i2c_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .fs_w1(fs_w1), .fs_w2(fs_w2), .fs_w3(fs_w3),
        .hs_w1(hs_w1), .hs_w2(hs_w2), .hs_w3(hs_w3), .hold_w(hold_w),
        .hs_enable(hs_enable), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .scl_in(scl_in), .scl_pull_low(scl_pull_low), .cmd_ready(cmd_ready),
        .evt_sda_fall(evt_sda_fall), .evt_sda_rise(evt_sda_rise),
        .evt_data(evt_data), .evt_sample(evt_sample), .done(done),
        .hs_bank_active(hs_bank_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Timing words with junk in the bits that must be ignored (R1).
    function automatic logic [31:0] mk_w1(input int su, input int hd, input int ps);
        return {su[7:0], hd[7:0], ps[7:0], 8'hC3};
    endfunction
    function automatic logic [31:0] mk_w2(input int lo, input int hi);
        return {8'hA5, 8'h5A, lo[7:0], hi[7:0]};
    endfunction
    function automatic logic [31:0] mk_w3(input int dv, input int sr);
        return {8'h3C, dv[7:0], 8'h96, sr[7:0]};
    endfunction

    int D, L, H, SU, HD, PS, SR, DH, F;

    task automatic load_fast();
        fs_w1  = mk_w1(SU, HD, PS);
        fs_w2  = mk_w2(L, H);
        fs_w3  = mk_w3(D, SR);
        hold_w = {24'hF0F0F0, DH[7:0]};
        cfg_word = {13'h1ABC, F[2:0], 16'hBEEF};
    endtask

    function automatic int t_lo();  return (L + 1) * (D + 1); endfunction
    function automatic int t_ovh(); return 8 + F; endfunction
    function automatic int t_start(); return (SU + 1) * (D + 1) + (HD + 1) * (D + 1); endfunction

    // Driver: issues a command and pushes its expected result.
    task automatic issue(input int op, input int len, input int evt_off, input string req);
        exp_t it;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op[1:0];
        @(posedge clk);
        #1;
        it.t_done = cyc + len - 1;
        it.t_evt  = (evt_off > 0) ? cyc + evt_off - 1 : -1;
        it.req    = req;
        sb.push_back(it);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_empty();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int op, input int len, input int evt_off, input string req);
        issue(op, len, evt_off, req);
        wait_empty();
    endtask

    task automatic ignored(input int op, input bit exp_low, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op[1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk(scl_pull_low == exp_low, req, scl_pull_low, exp_low);
        chk(cmd_ready == 1'b1, req, cmd_ready, 1);
    endtask

    // Monitor: compares results with the scoreboard as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((evt_sda_fall || evt_data) && !evt_seen) begin
                evt_seen = 1'b1;
                evt_cyc  = cyc;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", cyc, -1);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(cyc == it.t_done, it.req, cyc, it.t_done);
                    if (it.t_evt >= 0)
                        chk(evt_seen && (evt_cyc == it.t_evt), {it.req, " event"}, evt_cyc, it.t_evt);
                end
                evt_seen = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        D = 3; L = 6; H = 5; SU = 4; HD = 3; PS = 5; SR = 2; DH = 2; F = 0;
        load_fast();
        hs_w1 = mk_w1(1, 1, 2);
        hs_w2 = mk_w2(2, 1);
        hs_w3 = mk_w3(0, 1);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(scl_pull_low == 1'b0, "R11 scl released", scl_pull_low, 0);
        chk(cmd_ready == 1'b1, "R11 ready", cmd_ready, 1);
        chk({evt_sda_fall, evt_sda_rise, evt_data, evt_sample, done} == 5'b0, "R11 strobes", 1, 0);
        chk(hs_bank_active == 1'b0, "R11 fast bank", hs_bank_active, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 bit and stop on a free bus are ignored
        ignored(1, 1'b0, "R9 bit while free");
        ignored(3, 1'b0, "R9 stop while free");
        // R3 start: 20 + 16 = 36, fall at 20
        run(0, t_start(), (SU + 1) * (D + 1), "R3 start");
        chk(scl_pull_low == 1'b1, "R3 held low after start", scl_pull_low, 1);
        // R9 start on a held bus is ignored
        ignored(0, 1'b1, "R9 start while held");
        // R1 bit period 4*13+8 = 60, R4 data event at 12
        run(1, (D + 1) * (L + H + 2) + 8 + F, (DH + 1) * (D + 1), "R1 R4 bit period");
        // R2 filter cycles from cfg bits [18:16]
        F = 5; load_fast();
        run(1, (D + 1) * (L + H + 2) + 8 + F, (DH + 1) * (D + 1), "R2 filter adds");
        F = 0; load_fast();
        // R6 repeated start
        run(2, t_lo() + t_ovh() + (SR + 1) * (D + 1) + t_start(), (DH + 1) * (D + 1), "R6 restart");
        chk(scl_pull_low == 1'b1, "R6 held low after restart", scl_pull_low, 1);
        // R7 clock stretching: line held low until clock X of the release phase
        begin
            int x;
            x = 30;
            stretch_hold = 1'b1;
            issue(1, t_lo() + x + 2 + (H + 1) * (D + 1), (DH + 1) * (D + 1), "R7 stretch");
            for (int k = 1; k <= t_lo() + x; k++) @(negedge clk);
            stretch_hold = 1'b0;
            wait_empty();
        end
        // R10 words changed mid-command do not affect it
        issue(1, (D + 1) * (L + H + 2) + 8 + F, (DH + 1) * (D + 1), "R10 latched timing");
        repeat (5) @(negedge clk);
        fs_w2 = mk_w2(20, 20);
        fs_w3 = mk_w3(7, 9);
        cfg_word[18:16] = 3'd7;
        wait_empty();
        load_fast();
        // R5 stop
        run(3, t_lo() + t_ovh() + (PS + 1) * (D + 1), (DH + 1) * (D + 1), "R5 stop");
        chk(scl_pull_low == 1'b0 && cmd_ready == 1'b1, "R5 bus free after stop", scl_pull_low, 0);

        // Minimum settings: DIV 0, SCL_L+SCL_H = 2, data hold 0, filter 7
        D = 0; L = 1; H = 1; SU = 1; HD = 1; PS = 2; DH = 0; F = 7; load_fast();
        run(0, t_start(), (SU + 1) * (D + 1), "R3 start min div");
        run(1, (D + 1) * (L + H + 2) + 8 + F, (DH + 1) * (D + 1), "R1 R2 bit min");
        run(3, t_lo() + t_ovh() + (PS + 1) * (D + 1), (DH + 1) * (D + 1), "R5 stop min");

        // Maximum divider
        D = 255; L = 1; H = 1; SU = 0; HD = 0; PS = 0; DH = 1; F = 0; load_fast();
        run(0, t_start(), (SU + 1) * (D + 1), "R3 start max div");
        run(1, (D + 1) * (L + H + 2) + 8 + F, (DH + 1) * (D + 1), "R1 bit max div");
        run(3, t_lo() + t_ovh() + (PS + 1) * (D + 1), (DH + 1) * (D + 1), "R5 stop max div");

        // R8 bank switching after the master-code bits
        D = 3; L = 6; H = 5; SU = 4; HD = 3; PS = 5; SR = 2; DH = 2; F = 0; load_fast();
        hs_enable = 1'b1;
        run(0, t_start(), (SU + 1) * (D + 1), "R8 start on fast bank");
        for (int b = 0; b < 9; b++)
            run(1, (D + 1) * (L + H + 2) + 8, (DH + 1) * (D + 1), "R8 master-code bit fast");
        chk(hs_bank_active == 1'b1, "R8 high-speed bank after ninth bit", hs_bank_active, 1);
        // High-speed bank: DIV 0, low 2, high 1, stop setup 2, data hold 2
        run(1, 1 * (2 + 1 + 2) + 8, 3, "R8 bit on high-speed bank");
        run(3, 3 + 8 + 3, 3, "R8 stop on high-speed bank");
        chk(hs_bank_active == 1'b0, "R8 fast bank after stop", hs_bank_active, 0);
        hs_enable = 1'b0;

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        summary();
        $finish;
    end
endmodule